// File: doc/BRIEF.md
# Reservation Monitor for Load-Reserve / Store-Conditional

This block holds one reservation for an atomic read-modify-write sequence. A load-reserve request installs the reservation. It stores the effective address and the access length and raises a reservation flag. A later store-conditional request is judged against that reservation.

The store-conditional succeeds only while the flag is up, the stored length is one word (4 bytes) and the stored address equals the store's address. The block answers one cycle after the store-conditional strobe. It gives a store-permit bit, which gates the memory write, and a 4-bit condition code. The code carries the success flag and a copy of the sticky summary-overflow input. Every store-conditional drops the reservation, whether it passed or failed.

An external clear input, for instance from interrupt entry, also drops the reservation. The memory array and any coherence snooping sit outside this block.

Top module: `lrsc_monitor`

## Requirements
- R1: A load-reserve strobe (`lr_req`) without `rsv_clear` sets the reservation flag and records `lr_addr` and `lr_len` for the next cycle.
- R2: A store-conditional succeeds only if all three hold: the flag is set, the recorded length equals 4, and the recorded address equals `sc_addr`. Any other case fails.
- R3: `cond_code` is 4 bits. Bit 1 is 1 on success. Bit 0 equals `so_flag` as sampled with the strobe. Bits 3:2 are 0. Success gives 0x2 or 0x3, and failure gives 0x0 or 0x1.
- R4: Every store-conditional clears the reservation, passing or failing, so a repeat to the same address fails.
- R5: `store_permit` is high only in the response cycle of a successful store-conditional.
- R6: A new load-reserve replaces an existing reservation. A store-conditional to the old address then fails, and one to the new address succeeds.
- R7: `rsv_clear` drops the reservation. It wins over a load-reserve in the same cycle, and it forces a store-conditional in the same cycle to fail.
- R8: `resp_valid`, `store_permit` and `cond_code` change one cycle after `sc_req`. When no response is due, `resp_valid` and `store_permit` are 0 and `cond_code` is 0x0.
- R9: Synchronous active-high reset clears the reservation and drives all outputs to 0.
- R10: If a load-reserve and a store-conditional arrive in the same cycle, the store-conditional is judged against the earlier reservation, and the new reservation is installed afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lr_req | input | 1 | Load-reserve strobe |
| lr_addr | input | ADDR_W | Load-reserve effective address |
| lr_len | input | LEN_W | Load-reserve access length in bytes |
| sc_req | input | 1 | Store-conditional strobe |
| sc_addr | input | ADDR_W | Store-conditional effective address |
| so_flag | input | 1 | Sticky summary-overflow bit |
| rsv_clear | input | 1 | External reservation drop |
| resp_valid | output | 1 | Store-conditional response present |
| store_permit | output | 1 | Memory write allowed |
| cond_code | output | 4 | Condition-code result |

## Verification
The hardest cases to reach are the same-cycle collisions. One is a load-reserve together with a store-conditional, where the old reservation must decide the outcome and the new one must survive. The other is the external clear landing on either strobe. The vector table sets up a known reservation first, then drives both strobes, or a strobe and the clear, in one cycle. It then probes the surviving state with a follow-up store-conditional, because the reservation is visible only through that response.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;

    localparam int CC_W         = 4;
    localparam int CC_OK_BIT    = 1;
    localparam int CC_SO_BIT    = 0;
    localparam int WORD_BYTES   = 4;

    typedef logic [CC_W-1:0] cc_t;

    typedef struct packed {
        logic valid;
        logic permit;
        cc_t  cc;
    } sc_resp_t;

    function automatic cc_t make_cc(input logic ok, input logic so);
        cc_t c;
        c = '0;
        c[CC_OK_BIT] = ok;
        c[CC_SO_BIT] = so;
        return c;
    endfunction

endpackage

// File: rtl/rsv_store.sv
module rsv_store #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_i,
    input  logic [ADDR_W-1:0] set_addr_i,
    input  logic [LEN_W-1:0]  set_len_i,
    input  logic              drop_i,
    input  logic              kill_i,
    output logic              valid_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [LEN_W-1:0]  len_o
);

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
    } rsv_t;

    rsv_t cur_q, nxt;

    always_comb begin
        nxt = cur_q;
        if (kill_i) begin
            nxt.valid = 1'b0;
        end else if (set_i) begin
            nxt.valid = 1'b1;
            nxt.addr  = set_addr_i;
            nxt.len   = set_len_i;
        end else if (drop_i) begin
            nxt.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt;
        end
    end

    assign valid_o = cur_q.valid;
    assign addr_o  = cur_q.addr;
    assign len_o   = cur_q.len;

    AST_LR_RECORDS: assert property (@(posedge clk) disable iff (rst)
        (set_i && !kill_i) |=> (valid_o && addr_o == $past(set_addr_i) && len_o == $past(set_len_i))); // R1
    AST_SC_DROPS: assert property (@(posedge clk) disable iff (rst)
        (drop_i && !set_i) |=> !valid_o); // R4
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
        kill_i |=> !valid_o); // R7

endmodule

// File: rtl/rsv_match.sv
module rsv_match
    import lrsc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 4
) (
    input  logic              valid_i,
    input  logic [ADDR_W-1:0] rsv_addr_i,
    input  logic [LEN_W-1:0]  rsv_len_i,
    input  logic [ADDR_W-1:0] sc_addr_i,
    input  logic              kill_i,
    output logic              hit_o
);

    localparam logic [LEN_W-1:0] WORD_LEN = LEN_W'(WORD_BYTES);

    logic addr_eq, len_ok;

    assign addr_eq = (rsv_addr_i == sc_addr_i);
    assign len_ok  = (rsv_len_i == WORD_LEN);
    assign hit_o   = valid_i && len_ok && addr_eq && !kill_i;

endmodule

// File: rtl/rsv_result.sv
module rsv_result
    import lrsc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sc_i,
    input  logic hit_i,
    input  logic so_i,
    output logic valid_o,
    output logic permit_o,
    output cc_t  cc_o
);

    sc_resp_t resp_q, resp_d;

    always_comb begin
        resp_d = '0;
        if (sc_i) begin
            resp_d.valid  = 1'b1;
            resp_d.permit = hit_i;
            resp_d.cc     = make_cc(hit_i, so_i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_q <= '0;
        end else begin
            resp_q <= resp_d;
        end
    end

    assign valid_o  = resp_q.valid;
    assign permit_o = resp_q.permit;
    assign cc_o     = resp_q.cc;

    AST_RESP_AFTER_SC: assert property (@(posedge clk) disable iff (rst)
        sc_i |=> valid_o); // R8
    AST_QUIET_NO_SC: assert property (@(posedge clk) disable iff (rst)
        !sc_i |=> (!valid_o && !permit_o && cc_o == '0)); // R8
    AST_SO_CARRIED: assert property (@(posedge clk) disable iff (rst)
        sc_i |=> (cc_o[CC_SO_BIT] == $past(so_i))); // R3

endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor
    import lrsc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lr_req,
    input  logic [ADDR_W-1:0] lr_addr,
    input  logic [LEN_W-1:0]  lr_len,
    input  logic              sc_req,
    input  logic [ADDR_W-1:0] sc_addr,
    input  logic              so_flag,
    input  logic              rsv_clear,
    output logic              resp_valid,
    output logic              store_permit,
    output logic [CC_W-1:0]   cond_code
);

    logic              rsv_valid;
    logic [ADDR_W-1:0] rsv_addr;
    logic [LEN_W-1:0]  rsv_len;
    logic              sc_hit;

    rsv_store #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_store (
        .clk        (clk),
        .rst        (rst),
        .set_i      (lr_req),
        .set_addr_i (lr_addr),
        .set_len_i  (lr_len),
        .drop_i     (sc_req),
        .kill_i     (rsv_clear),
        .valid_o    (rsv_valid),
        .addr_o     (rsv_addr),
        .len_o      (rsv_len)
    );

    rsv_match #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_match (
        .valid_i    (rsv_valid),
        .rsv_addr_i (rsv_addr),
        .rsv_len_i  (rsv_len),
        .sc_addr_i  (sc_addr),
        .kill_i     (rsv_clear),
        .hit_o      (sc_hit)
    );

    rsv_result u_result (
        .clk      (clk),
        .rst      (rst),
        .sc_i     (sc_req),
        .hit_i    (sc_hit),
        .so_i     (so_flag),
        .valid_o  (resp_valid),
        .permit_o (store_permit),
        .cc_o     (cond_code)
    );

    AST_NO_RSV_NO_PERMIT: assert property (@(posedge clk) disable iff (rst)
        (sc_req && !rsv_valid) |=> !store_permit); // R2
    AST_ADDR_MISS_FAILS: assert property (@(posedge clk) disable iff (rst)
        (sc_req && rsv_addr != sc_addr) |=> !store_permit); // R2
    AST_PERMIT_IN_RESP: assert property (@(posedge clk) disable iff (rst)
        store_permit |-> (resp_valid && cond_code[CC_OK_BIT])); // R5
    AST_CLEAR_FAILS_SC: assert property (@(posedge clk) disable iff (rst)
        (sc_req && rsv_clear) |=> !store_permit); // R7

endmodule

// File: tb/tb_lrsc_monitor.sv
module tb_lrsc_monitor;

    localparam int AW = 32;
    localparam int LW = 4;
    localparam logic [AW-1:0] A = 32'h0000_1000;
    localparam logic [AW-1:0] B = 32'h0000_2000;

    typedef struct packed {
        logic          lr;
        logic [AW-1:0] la;
        logic [LW-1:0] ll;
        logic          sc;
        logic [AW-1:0] sa;
        logic          so;
        logic          clr;
        logic [3:0]    rq;
        logic          ev;
        logic          ep;
        logic [3:0]    ec;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VEC [NV] = '{
        //  lr   la  ll    sc   sa  so   clr  req  ev   ep   ec
        '{1'b1, A, 4'd4, 1'b0, A, 1'b0, 1'b0, 4'd1, 1'b0, 1'b0, 4'h0}, // R1 reserve A
        '{1'b0, A, 4'd4, 1'b1, A, 1'b0, 1'b0, 4'd2, 1'b1, 1'b1, 4'h2}, // R2 match
        '{1'b0, A, 4'd4, 1'b1, A, 1'b0, 1'b0, 4'd4, 1'b1, 1'b0, 4'h0}, // R4 repeat fails
        '{1'b1, A, 4'd4, 1'b0, A, 1'b0, 1'b0, 4'd1, 1'b0, 1'b0, 4'h0},
        '{1'b0, A, 4'd4, 1'b1, B, 1'b0, 1'b0, 4'd2, 1'b1, 1'b0, 4'h0}, // R2 address miss
        '{1'b0, A, 4'd4, 1'b1, A, 1'b0, 1'b0, 4'd4, 1'b1, 1'b0, 4'h0}, // R4 failed SC also cleared
        '{1'b1, A, 4'd8, 1'b0, A, 1'b0, 1'b0, 4'd1, 1'b0, 1'b0, 4'h0},
        '{1'b0, A, 4'd4, 1'b1, A, 1'b0, 1'b0, 4'd2, 1'b1, 1'b0, 4'h0}, // R2 length not 4
        '{1'b1, A, 4'd4, 1'b0, A, 1'b0, 1'b0, 4'd6, 1'b0, 1'b0, 4'h0},
        '{1'b1, B, 4'd4, 1'b0, A, 1'b0, 1'b0, 4'd6, 1'b0, 1'b0, 4'h0}, // R6 replace
        '{1'b0, A, 4'd4, 1'b1, A, 1'b0, 1'b0, 4'd6, 1'b1, 1'b0, 4'h0}, // R6 old address fails
        '{1'b1, B, 4'd4, 1'b0, A, 1'b0, 1'b0, 4'd6, 1'b0, 1'b0, 4'h0},
        '{1'b0, A, 4'd4, 1'b1, B, 1'b1, 1'b0, 4'd3, 1'b1, 1'b1, 4'h3}, // R3 success with SO
        '{1'b0, A, 4'd4, 1'b1, B, 1'b1, 1'b0, 4'd3, 1'b1, 1'b0, 4'h1}, // R3 failure with SO
        '{1'b1, A, 4'd4, 1'b0, A, 1'b0, 1'b0, 4'd7, 1'b0, 1'b0, 4'h0},
        '{1'b0, A, 4'd4, 1'b0, A, 1'b0, 1'b1, 4'd7, 1'b0, 1'b0, 4'h0}, // R7 clear
        '{1'b0, A, 4'd4, 1'b1, A, 1'b0, 1'b0, 4'd7, 1'b1, 1'b0, 4'h0}, // R7 dropped
        '{1'b1, A, 4'd4, 1'b0, A, 1'b0, 1'b0, 4'd7, 1'b0, 1'b0, 4'h0},
        '{1'b0, A, 4'd4, 1'b1, A, 1'b0, 1'b1, 4'd7, 1'b1, 1'b0, 4'h0}, // R7 clear with SC
        '{1'b0, A, 4'd4, 1'b1, A, 1'b0, 1'b0, 4'd7, 1'b1, 1'b0, 4'h0},
        '{1'b1, A, 4'd4, 1'b0, A, 1'b0, 1'b1, 4'd7, 1'b0, 1'b0, 4'h0}, // R7 clear beats LR
        '{1'b0, A, 4'd4, 1'b1, A, 1'b0, 1'b0, 4'd7, 1'b1, 1'b0, 4'h0},
        '{1'b1, A, 4'd4, 1'b0, A, 1'b0, 1'b0, 4'd10, 1'b0, 1'b0, 4'h0},
        '{1'b1, B, 4'd4, 1'b1, A, 1'b0, 1'b0, 4'd10, 1'b1, 1'b1, 4'h2}, // R10 old rsv decides
        '{1'b0, A, 4'd4, 1'b1, B, 1'b0, 1'b0, 4'd10, 1'b1, 1'b1, 4'h2}, // R10 new rsv kept
        '{1'b0, A, 4'd4, 1'b0, A, 1'b1, 1'b0, 4'd8, 1'b0, 1'b0, 4'h0}  // R8 idle is quiet
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          lr_req = 1'b0;
    logic [AW-1:0] lr_addr = '0;
    logic [LW-1:0] lr_len = '0;
    logic          sc_req = 1'b0;
    logic [AW-1:0] sc_addr = '0;
    logic          so_flag = 1'b0;
    logic          rsv_clear = 1'b0;
    logic          resp_valid;
    logic          store_permit;
    logic [3:0]    cond_code;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    lrsc_monitor #(.ADDR_W(AW), .LEN_W(LW)) dut (
        .clk(clk), .rst(rst),
        .lr_req(lr_req), .lr_addr(lr_addr), .lr_len(lr_len),
        .sc_req(sc_req), .sc_addr(sc_addr), .so_flag(so_flag),
        .rsv_clear(rsv_clear),
        .resp_valid(resp_valid), .store_permit(store_permit), .cond_code(cond_code)
    );

    task automatic check(input string tag, input logic ev, input logic ep, input logic [3:0] ec);
        n_chk++;
        if (resp_valid !== ev || store_permit !== ep || cond_code !== ec) begin
            n_bad++;
            $display("FAIL %s: got valid=%b permit=%b cc=%h, expected valid=%b permit=%b cc=%h",
                     tag, resp_valid, store_permit, cond_code, ev, ep, ec);
        end
    endtask

    task automatic drive(input vec_t v);
        @(negedge clk);
        lr_req = v.lr; lr_addr = v.la; lr_len = v.ll;
        sc_req = v.sc; sc_addr = v.sa; so_flag = v.so; rsv_clear = v.clr;
        @(posedge clk);
        #2;
    endtask

    task automatic idle();
        @(negedge clk);
        lr_req = 1'b0; sc_req = 1'b0; rsv_clear = 1'b0; so_flag = 1'b0;
    endtask

    initial begin
        #(20 * 5000);
        n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check("R9 outputs in reset", 1'b0, 1'b0, 4'h0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            check($sformatf("R%0d vector %0d", VEC[i].rq, i), VEC[i].ev, VEC[i].ep, VEC[i].ec);
        end
        idle();

        // R8: no response before the edge, response after it, gone one cycle later
        drive('{1'b1, A, 4'd4, 1'b0, A, 1'b0, 1'b0, 4'd8, 1'b0, 1'b0, 4'h0});
        @(negedge clk);
        lr_req = 1'b0; sc_req = 1'b1; sc_addr = A;
        #5;
        check("R8 before edge", 1'b0, 1'b0, 4'h0);
        @(posedge clk); #2;
        check("R8 after edge", 1'b1, 1'b1, 4'h2);
        idle();
        @(posedge clk); #2;
        check("R8 pulse ends", 1'b0, 1'b0, 4'h0);

        // R9: reset drops a live reservation
        drive('{1'b1, B, 4'd4, 1'b0, A, 1'b0, 1'b0, 4'd9, 1'b0, 1'b0, 4'h0});
        idle();
        rst = 1'b1;
        @(posedge clk); #2;
        check("R9 reset state", 1'b0, 1'b0, 4'h0);
        @(negedge clk);
        rst = 1'b0;
        drive('{1'b0, A, 4'd4, 1'b1, B, 1'b0, 1'b0, 4'd9, 1'b1, 1'b0, 4'h0});
        check("R9 reservation gone after reset", 1'b1, 1'b0, 4'h0);
        idle();

        // R5: permit only on success, including with SO set on a miss
        drive('{1'b1, A, 4'd4, 1'b0, A, 1'b0, 1'b0, 4'd5, 1'b0, 1'b0, 4'h0});
        drive('{1'b0, A, 4'd4, 1'b1, A, 1'b1, 1'b0, 4'd5, 1'b1, 1'b1, 4'h3});
        check("R5 permit on success", 1'b1, 1'b1, 4'h3);
        drive('{1'b0, A, 4'd4, 1'b1, A, 1'b1, 1'b0, 4'd5, 1'b1, 1'b0, 4'h1});
        check("R5 no permit on failure", 1'b1, 1'b0, 4'h1);
        idle();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule